// File: doc/BRIEF.md
# I2C Bus Condition and Error Monitor

This block watches the two wires of an I2C or SMBus bus and tells the master and slave engines of the same device what is happening on them. It receives SCL and SDA as seen at the pads, plus two indications of what this device itself is pulling low. Both inputs are synchronised and passed through a spike filter before any decision is made. A START, a repeated START or a STOP each produce a one-cycle strobe.

A small state machine keeps the bus state: unknown after reset, idle, owned by this device, or busy with another master. The monitor raises sticky flags for lost arbitration, for a START collision (the SMBus case where another master's START lands on a data bit this device is sending), and for a protocol error (a START or STOP in the middle of a byte). The flags stay set until they are cleared by writing ones. A live clock-hold indication shows when this device is keeping SCL low.

An external idle-timeout strobe can force the bus state to idle when the bus has been quiet for long enough. The timer that produces that strobe is outside this block.

Top module: `i2c_line_monitor`

## Requirements
- R1: A fall of filtered SDA while filtered SCL stays high gives a START condition. A rise of SDA while SCL stays high gives a STOP. A START seen in state unknown or idle pulses startStb for one cycle. A STOP pulses stopStb for one cycle and puts busState to idle.
- R2: Each line is synchronised and then filtered. A level that differs from the filtered value for fewer than 3 consecutive clock samples is ignored. A level that holds for 3 samples is taken.
- R3: A START seen while busState is owner or busy pulses rstartStb instead of startStb. startStb and rstartStb never pulse in the same cycle.
- R4: busState is encoded as 0 unknown, 1 idle, 2 owner, 3 busy, and it resets to 0. A START seen while sdaDrive is 1 gives owner. Any other START gives busy. A busTimeout pulse with no bus condition in the same cycle forces idle.
- R5: In state owner, a rise of SCL while sdaDrive is 0 but SDA reads low sets arbLost and moves busState to busy.
- R6: In state owner, a START seen while sdaDrive is 0 is a collision. It sets collision and arbLost, moves busState to busy and does not set busError.
- R7: In state owner or busy, let n be the number of SCL rises since the last START. A START or STOP sets busError unless n is 0, or n is 10 or more with n mod 9 equal to 1. For example, a STOP after 3 bits (n = 4) sets busError.
- R8: clkHold is 1 while sclDrive is 1 and filtered SCL is low. It is 0 when SCL is low only because another device pulls it.
- R9: arbLost, collision and busError are sticky. A one on flagClear bit 0 clears arbLost, on bit 1 clears collision, and on bit 2 clears busError. A clear bit leaves the other flags as they are.
- R10: A repeated START or a STOP that comes after a whole 9-bit byte does not set busError.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level as received from the bus |
| sdaIn | input | 1 | SDA level as received from the bus |
| sclDrive | input | 1 | 1 while this device pulls SCL low |
| sdaDrive | input | 1 | 1 while this device pulls SDA low |
| busTimeout | input | 1 | Pulse from an idle timer that forces the idle state |
| flagClear | input | 3 | Write-one-to-clear: bit 0 arbLost, bit 1 collision, bit 2 busError |
| startStb | output | 1 | One-cycle strobe for a START from unknown or idle |
| rstartStb | output | 1 | One-cycle strobe for a repeated START |
| stopStb | output | 1 | One-cycle strobe for a STOP |
| busState | output | 2 | 0 unknown, 1 idle, 2 owner, 3 busy |
| arbLost | output | 1 | Sticky arbitration-lost flag |
| collision | output | 1 | Sticky START-versus-data-bit collision flag |
| busError | output | 1 | Sticky misplaced START or STOP flag |
| clkHold | output | 1 | This device is holding SCL low |

## Verification
The bench sends a two-cycle and a three-cycle SDA pulse while SCL is high. A filter that is one sample too short turns the two-cycle pulse into a START/STOP pair, and one that is too long loses the three-cycle pulse. The counting of SCL rises is checked at both edges of the legal window. A repeated START and a STOP after a whole byte must stay error-free, while a STOP after three bits must set busError, so an off-by-one in the bit position shows up on one side or the other. The SMBus collision is made by pulling SDA while this device releases a data bit in the middle of a byte. A design that treated it as a plain misplaced START would raise busError, and one that missed it would leave busState at owner.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  typedef enum logic [1:0] {
    BUS_UNKNOWN = 2'd0,
    BUS_IDLE    = 2'd1,
    BUS_OWNER   = 2'd2,
    BUS_BUSY    = 2'd3
  } busState_t;

  // Line events from the datapath to the control
  typedef struct packed {
    logic startCond;
    logic stopCond;
    logic sclRise;
    logic sclHigh;
    logic sdaHigh;
  } lineEvt_t;

  // Flag-set strobes from the control to the datapath
  typedef struct packed {
    logic setBusErr;
    logic setCollision;
    logic setArbLost;
  } flagSet_t;

  localparam int unsigned NUM_FLAGS = 3;

endpackage

// File: rtl/i2c_mon_filter.sv
module i2c_mon_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int unsigned CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic [CNT_W-1:0]       diffCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end

  assign syncOut = syncQ[SYNC_STAGES-1];

  // Adopt a new level only after it has differed for FILT_LEN samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diffCnt <= '0;
      lineOut <= 1'b1;
    end else if (syncOut != lineOut) begin
      if (diffCnt == CNT_LAST) begin
        lineOut <= syncOut;
        diffCnt <= '0;
      end else begin
        diffCnt <= diffCnt + 1'b1;
      end
    end else begin
      diffCnt <= '0;
    end
  end

  AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((FILT_LEN >= 3) && !$stable(lineOut)) |->
      ($past(syncOut, 1) == lineOut && $past(syncOut, 2) == lineOut)); // R2

endmodule

// File: rtl/i2c_mon_datapath.sv
module i2c_mon_datapath
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 sclDrive,
  input  logic [NUM_FLAGS-1:0] flagClear,
  input  flagSet_t             flagSet,
  output lineEvt_t             lineEvt,
  output logic                 arbLost,
  output logic                 collision,
  output logic                 busError,
  output logic                 clkHold
);
  localparam int unsigned NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLine;
  logic [NUM_LINES-1:0] filtLine;
  logic [NUM_LINES-1:0] prevLine;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] flagSetVec;
  logic                 sclNow, sdaNow, sclWas, sdaWas;

  assign rawLine = {sdaIn, sclIn};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2c_mon_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) i_filter (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (rawLine[g]),
      .lineOut(filtLine[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLine <= '1;
    else       prevLine <= filtLine;
  end

  assign sclNow = filtLine[0];
  assign sdaNow = filtLine[1];
  assign sclWas = prevLine[0];
  assign sdaWas = prevLine[1];

  always_comb begin
    lineEvt.startCond = sclWas && sclNow && sdaWas && !sdaNow;
    lineEvt.stopCond  = sclWas && sclNow && !sdaWas && sdaNow;
    lineEvt.sclRise   = !sclWas && sclNow;
    lineEvt.sclHigh   = sclNow;
    lineEvt.sdaHigh   = sdaNow;
  end

  // Sticky flags: bit 0 arbitration lost, bit 1 collision, bit 2 bus error
  assign flagSetVec = {flagSet.setBusErr, flagSet.setCollision, flagSet.setArbLost};

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[f] <= 1'b0;
      else       flagQ[f] <= flagSetVec[f] | (flagQ[f] & ~flagClear[f]);
    end
  end

  assign arbLost   = flagQ[0];
  assign collision = flagQ[1];
  assign busError  = flagQ[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkHold <= 1'b0;
    else       clkHold <= sclDrive && !sclNow;
  end

  AST_COLL_WITH_ARB: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collision) |-> arbLost); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(arbLost) && !$past(flagClear[0])) |-> arbLost); // R9

  AST_CLKHOLD_OWN: assert property (@(posedge clk) disable iff (!rstN)
    clkHold |-> $past(sclDrive)); // R8

  AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lineEvt.startCond, lineEvt.stopCond, lineEvt.sclRise})); // R1

endmodule

// File: rtl/i2c_mon_control.sv
module i2c_mon_control
  import i2c_mon_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  lineEvt_t  lineEvt,
  input  logic      sdaDrive,
  input  logic      busTimeout,
  output flagSet_t  flagSet,
  output logic      startStb,
  output logic      rstartStb,
  output logic      stopStb,
  output busState_t busState
);
  localparam int unsigned POS_W = $clog2(FRAME_BITS + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS);

  logic [POS_W-1:0] bitPos;
  logic             byteWrapped;
  logic             active;
  logic             legalPos;
  logic             collide;
  logic             arbMiss;
  logic             condSeen;
  busState_t        nextState;

  assign active   = (busState == BUS_OWNER) || (busState == BUS_BUSY);
  assign legalPos = (bitPos == '0) || (bitPos == POS_W'(1) && byteWrapped);
  assign collide  = lineEvt.startCond && (busState == BUS_OWNER) && !sdaDrive;
  assign arbMiss  = lineEvt.sclRise && (busState == BUS_OWNER) && !sdaDrive &&
                    !lineEvt.sdaHigh;
  assign condSeen = lineEvt.startCond || lineEvt.stopCond;

  always_comb begin
    flagSet.setArbLost   = arbMiss || collide;
    flagSet.setCollision = collide;
    flagSet.setBusErr    = condSeen && active && !legalPos && !collide;
  end

  always_comb begin
    nextState = busState;
    if (lineEvt.stopCond)       nextState = BUS_IDLE;
    else if (lineEvt.startCond) nextState = (collide || !sdaDrive) ? BUS_BUSY : BUS_OWNER;
    else if (arbMiss)           nextState = BUS_BUSY;
    else if (busTimeout)        nextState = BUS_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busState  <= BUS_UNKNOWN;
      startStb  <= 1'b0;
      rstartStb <= 1'b0;
      stopStb   <= 1'b0;
    end else begin
      busState  <= nextState;
      startStb  <= lineEvt.startCond && !active;
      rstartStb <= lineEvt.startCond && active;
      stopStb   <= lineEvt.stopCond;
    end
  end

  // Bit position inside the current byte, counted on SCL rises
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos      <= '0;
      byteWrapped <= 1'b0;
    end else if (condSeen || !active) begin
      bitPos      <= '0;
      byteWrapped <= 1'b0;
    end else if (lineEvt.sclRise) begin
      if (bitPos == POS_LAST) begin
        bitPos      <= POS_W'(1);
        byteWrapped <= 1'b1;
      end else begin
        bitPos <= bitPos + 1'b1;
      end
    end
  end

  AST_ONE_CONDITION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startStb, rstartStb, stopStb})); // R3

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopStb |-> busState == BUS_IDLE); // R1

  AST_RSTART_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    rstartStb |-> ($past(busState) == BUS_OWNER || $past(busState) == BUS_BUSY)); // R3

  AST_COLLIDE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    flagSet.setCollision |=> busState == BUS_BUSY); // R6

endmodule

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned FRAME_BITS  = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       sclDrive,
  input  logic       sdaDrive,
  input  logic       busTimeout,
  input  logic [2:0] flagClear,
  output logic       startStb,
  output logic       rstartStb,
  output logic       stopStb,
  output logic [1:0] busState,
  output logic       arbLost,
  output logic       collision,
  output logic       busError,
  output logic       clkHold
);
  lineEvt_t  lineEvt;
  flagSet_t  flagSet;
  busState_t stateQ;

  i2c_mon_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclDrive (sclDrive),
    .flagClear(flagClear),
    .flagSet  (flagSet),
    .lineEvt  (lineEvt),
    .arbLost  (arbLost),
    .collision(collision),
    .busError (busError),
    .clkHold  (clkHold)
  );

  i2c_mon_control #(
    .FRAME_BITS(FRAME_BITS)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .lineEvt   (lineEvt),
    .sdaDrive  (sdaDrive),
    .busTimeout(busTimeout),
    .flagSet   (flagSet),
    .startStb  (startStb),
    .rstartStb (rstartStb),
    .stopStb   (stopStb),
    .busState  (stateQ)
  );

  assign busState = stateQ;

endmodule

// File: tb/test_i2c_line_monitor.sv
module test_i2c_line_monitor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extSclLow = 1'b0, extSdaLow = 1'b0;
  logic sclDrive = 1'b0, sdaDrive = 1'b0;
  logic busTimeout = 1'b0;
  logic [2:0] flagClear = 3'b000;
  logic startStb, rstartStb, stopStb, arbLost, collision, busError, clkHold;
  logic [1:0] busState;
  logic sclIn, sdaIn;

  int errors = 0, checks = 0;
  int nStart = 0, nRstart = 0, nStop = 0;

  assign sclIn = ~(extSclLow | sclDrive);
  assign sdaIn = ~(extSdaLow | sdaDrive);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_line_monitor i_i2c_line_monitor (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDrive(sclDrive), .sdaDrive(sdaDrive), .busTimeout(busTimeout),
    .flagClear(flagClear), .startStb(startStb), .rstartStb(rstartStb),
    .stopStb(stopStb), .busState(busState), .arbLost(arbLost),
    .collision(collision), .busError(busError), .clkHold(clkHold)
  );

  always @(negedge clk) begin
    if (startStb)  nStart++;
    if (rstartStb) nRstart++;
    if (stopStb)   nStop++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    repeat (8) @(negedge clk);
  endtask

  task automatic pulseIn(input logic isClear, input logic [2:0] val);
    @(negedge clk);
    if (isClear) flagClear = val; else busTimeout = 1'b1;
    @(negedge clk);
    flagClear = 3'b000;
    busTimeout = 1'b0;
    step();
  endtask

  // One bit: SCL low, set SDA, SCL high (ends with SCL high)
  task automatic sendBit(input logic ownLow, input logic extLow);
    extSclLow = 1'b1; step();
    sdaDrive = ownLow; extSdaLow = extLow; step();
    extSclLow = 1'b0; step();
  endtask

  task automatic stopOwn();
    extSclLow = 1'b1; step();
    sdaDrive = 1'b1; extSdaLow = 1'b0; step();
    extSclLow = 1'b0; step();
    sdaDrive = 1'b0; step();
  endtask

  task automatic stopExt();
    extSclLow = 1'b1; step();
    sdaDrive = 1'b0; extSdaLow = 1'b1; step();
    extSclLow = 1'b0; step();
    extSdaLow = 1'b0; step();
  endtask

  task automatic tReset();
    chk("R4 reset state unknown", busState, 0);
    chk("R9 reset flags", {arbLost, collision, busError}, 0);
    chk("R1 reset strobes", nStart + nRstart + nStop, 0);
  endtask

  task automatic tGlitch();
    @(negedge clk); extSdaLow = 1'b1;
    repeat (2) @(negedge clk); extSdaLow = 1'b0;
    step();
    chk("R2 two-cycle spike ignored", nStart + nStop, 0);
    chk("R2 state unchanged by spike", busState, 0);
    @(negedge clk); extSdaLow = 1'b1;
    repeat (3) @(negedge clk); extSdaLow = 1'b0;
    step();
    chk("R2 three-cycle pulse start", nStart, 1);
    chk("R1 stop counted", nStop, 1);
    chk("R1 stop gives idle", busState, 1);
  endtask

  task automatic tTimeout();
    extSdaLow = 1'b1; step();
    chk("R4 external start gives busy", busState, 3);
    pulseIn(1'b0, 3'b000);
    chk("R4 timeout forces idle", busState, 1);
    extSdaLow = 1'b0; step();
    chk("R1 stop while idle keeps idle", busState, 1);
    chk("R7 no error outside transfer", busError, 0);
  endtask

  task automatic tOwnTransfer();
    int s0, r0;
    s0 = nStart; r0 = nRstart;
    sdaDrive = 1'b1; step();
    chk("R4 own start gives owner", busState, 2);
    chk("R1 start strobe", nStart - s0, 1);
    for (int i = 0; i < 9; i++) sendBit(i[0], 1'b0);
    extSclLow = 1'b1; step();
    sdaDrive = 1'b0; step();
    extSclLow = 1'b0; step();
    sdaDrive = 1'b1; step();
    chk("R3 repeated start strobe", nRstart - r0, 1);
    chk("R3 no plain start on repeat", nStart - s0, 1);
    chk("R10 repeat after byte no error", busError, 0);
    chk("R3 still owner", busState, 2);
    for (int i = 0; i < 9; i++) sendBit(~i[0], 1'b0);
    stopOwn();
    chk("R10 stop after byte no error", busError, 0);
    chk("R5 matching bits no arb loss", arbLost, 0);
    chk("R1 own stop idle", busState, 1);
  endtask

  task automatic tArbLoss();
    sdaDrive = 1'b1; step();
    sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b1);
    chk("R5 arbitration lost flag", arbLost, 1);
    chk("R5 state busy after loss", busState, 3);
    for (int i = 0; i < 7; i++) sendBit(1'b0, i[0]);
    stopExt();
    chk("R10 stop after byte after loss", busError, 0);
    chk("R9 arb flag sticky", arbLost, 1);
    pulseIn(1'b1, 3'b001);
    chk("R9 arb flag cleared", arbLost, 0);
  endtask

  task automatic tBusError();
    extSdaLow = 1'b1; step();
    for (int i = 0; i < 3; i++) sendBit(1'b0, 1'b1);
    stopExt();
    chk("R7 stop mid-byte error", busError, 1);
    pulseIn(1'b1, 3'b011);
    chk("R9 other clears keep error", busError, 1);
    pulseIn(1'b1, 3'b100);
    chk("R9 error cleared", busError, 0);
  endtask

  task automatic tCollision();
    int r0;
    r0 = nRstart;
    sdaDrive = 1'b1; step();
    for (int i = 0; i < 3; i++) sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b0);
    extSdaLow = 1'b1; step();
    chk("R6 collision flag", collision, 1);
    chk("R6 arb lost with collision", arbLost, 1);
    chk("R6 state busy", busState, 3);
    chk("R6 no bus error", busError, 0);
    chk("R3 colliding start is repeat", nRstart - r0, 1);
    extSdaLow = 1'b0; step();
    chk("R7 stop right after start legal", busError, 0);
    chk("R1 idle after stop", busState, 1);
    pulseIn(1'b1, 3'b011);
    chk("R9 collision cleared", collision, 0);
  endtask

  task automatic tClkHold();
    sclDrive = 1'b1; step();
    chk("R8 hold while driving", clkHold, 1);
    sclDrive = 1'b0; step();
    chk("R8 hold released", clkHold, 0);
    extSclLow = 1'b1; step();
    chk("R8 no hold when other pulls", clkHold, 0);
    extSclLow = 1'b0; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    tReset();
    tGlitch();
    tTimeout();
    tOwnTransfer();
    tArbLoss();
    tBusError();
    tCollision();
    tClkHold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule